// File: doc/BRIEF.md
# Multi-Queue Interrupt Register Bank

This block holds the interrupt state of a network controller that serves up to sixteen priority queues. Event pulses from the datapath arrive on one 32-bit lane per queue. Each lane's bits are latched into that queue's status word unless the matching mask bit is set. Queue 0 uses the global status, mask and strobe registers. Queues 1 to 15 each have their own status, mask, enable-strobe and disable-strobe words, and each configured queue drives one interrupt line.

Software reaches the bank over a simple 32-bit word-addressed bus. A read returns its data one cycle after the request. A read of a status word clears it. A read of the global status word also acknowledges every interrupt line at once. The per-queue strobe and mask words sit in two separate address windows, one for queues 1–7 and one for queues 8–15.

Top module: `mq_irq_regbank`

## Requirements
- R1: After reset every mask word reads 0xFFFFFFFF, every status word reads 0, and every interrupt line is low.
- R2: The global registers sit at byte offsets 0x024 (status), 0x028 (enable strobe), 0x02C (disable strobe) and 0x030 (mask). Lane 0 of the event input feeds the global status.
- R3: The status word of queue q (1..15) sits at byte 0x400 + 4·(q−1). Event lane q (bits 32q+31 down to 32q) feeds it.
- R4: A write to an enable strobe clears the written one-bits in that queue's mask, and a write to a disable strobe sets them. For queues 1–7 the enable strobes sit at 0x600 + 4·(q−1) and the disable strobes at 0x620 + 4·(q−1). For queues 8–15 the enable strobes sit at 0x660 + 4·(q−8) and the disable strobes at 0x680 + 4·(q−8).
- R5: The mask word of queue q reads back at 0x640 + 4·(q−1) for q = 1..7 and at 0x6A0 + 4·(q−8) for q = 8..15.
- R6: An event bit whose mask bit is 1 leaves the status unchanged and raises no interrupt.
- R7: A read of a status word returns its value from before the read and clears it. Event bits that arrive in the same cycle as the read remain set.
- R8: Interrupt line q rises in the cycle after new bits latch into queue q's status, where line 0 belongs to the global status. The line stays high while that status is non-zero and no acknowledge has occurred, and it drops when the status becomes zero.
- R9: A read of the global status word drops every interrupt line, including lines whose status stays non-zero. A line rises again only when new bits latch.
- R10: Strobe words read as 0. Writes to status words have no effect.
- R11: Registers of queues numbered NUM_Q or higher read as 0 and ignore writes.
- R12: rvalid_o is high for exactly one cycle, the cycle after each read request, and rdata_o carries the result in that cycle. Writes produce no rvalid_o.
- R13: NUM_Q must lie in 1..16, and an illegal value stops elaboration. The block has exactly NUM_Q interrupt outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Bus access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | AW | Word address (byte offset / 4) |
| wdata_i | input | DW | Write data |
| rdata_o | output | DW | Read data, valid with rvalid_o |
| rvalid_o | output | 1 | Read data valid |
| evt_i | input | NUM_Q·DW | Event pulses, one DW-bit lane per queue |
| irq_o | output | NUM_Q | Interrupt line per queue |

## Verification
The properties assume that the bus issues at most one access per cycle and that req_i is never undefined after reset. The property on acknowledge applies only to cycles in which no event bit arrives alongside the global status read. The stimulus keeps reads and writes at least one idle cycle apart and drives event lanes only in cycles where it is not also reading the global status word. The single exception is a deliberate same-cycle event and read on a queue status word, used to test that the event bits survive the clear.

// File: rtl/mqirq_pkg.sv
package mqirq_pkg;
  localparam int MAXQ = 16;

  typedef enum logic [2:0] {RK_NONE, RK_STAT, RK_MASK, RK_EN, RK_DIS} rkind_e;

  typedef struct packed {
    rkind_e     kind;
    logic [3:0] q;
  } rsel_t;

  // word addresses (byte offset / 4)
  localparam logic [9:0] GSTAT_W    = 10'h009;
  localparam logic [9:0] GEN_W      = 10'h00A;
  localparam logic [9:0] GDIS_W     = 10'h00B;
  localparam logic [9:0] GMASK_W    = 10'h00C;
  localparam logic [9:0] QSTAT_W    = 10'h100;
  localparam logic [9:0] QEN_LO_W   = 10'h180;
  localparam logic [9:0] QDIS_LO_W  = 10'h188;
  localparam logic [9:0] QMASK_LO_W = 10'h190;
  localparam logic [9:0] QEN_HI_W   = 10'h198;
  localparam logic [9:0] QDIS_HI_W  = 10'h1A0;
  localparam logic [9:0] QMASK_HI_W = 10'h1A8;
  localparam int LO_CNT = 7;
  localparam int HI_CNT = 8;
endpackage

// File: rtl/mqirq_decode.sv
module mqirq_decode
  import mqirq_pkg::*;
#(
  parameter int AW    = 10,
  parameter int NUM_Q = 16
) (
  input  logic [AW-1:0] addr_i,
  output rsel_t         sel_o
);
  localparam int QBITS = 4;

  logic [AW-1:0] off_st, off_el, off_dl, off_ml, off_eh, off_dh, off_mh;
  rsel_t         raw;

  always_comb begin
    off_st = addr_i - AW'(QSTAT_W);
    off_el = addr_i - AW'(QEN_LO_W);
    off_dl = addr_i - AW'(QDIS_LO_W);
    off_ml = addr_i - AW'(QMASK_LO_W);
    off_eh = addr_i - AW'(QEN_HI_W);
    off_dh = addr_i - AW'(QDIS_HI_W);
    off_mh = addr_i - AW'(QMASK_HI_W);

    raw.kind = RK_NONE;
    raw.q    = '0;
    if      (addr_i == AW'(GSTAT_W)) raw.kind = RK_STAT;
    else if (addr_i == AW'(GEN_W))   raw.kind = RK_EN;
    else if (addr_i == AW'(GDIS_W))  raw.kind = RK_DIS;
    else if (addr_i == AW'(GMASK_W)) raw.kind = RK_MASK;
    else if (off_st < AW'(MAXQ-1)) begin
      raw.kind = RK_STAT; raw.q = QBITS'(off_st) + 4'd1;
    end else if (off_el < AW'(LO_CNT)) begin
      raw.kind = RK_EN;   raw.q = QBITS'(off_el) + 4'd1;
    end else if (off_dl < AW'(LO_CNT)) begin
      raw.kind = RK_DIS;  raw.q = QBITS'(off_dl) + 4'd1;
    end else if (off_ml < AW'(LO_CNT)) begin
      raw.kind = RK_MASK; raw.q = QBITS'(off_ml) + 4'd1;
    end else if (off_eh < AW'(HI_CNT)) begin
      raw.kind = RK_EN;   raw.q = QBITS'(off_eh) + 4'd8;
    end else if (off_dh < AW'(HI_CNT)) begin
      raw.kind = RK_DIS;  raw.q = QBITS'(off_dh) + 4'd8;
    end else if (off_mh < AW'(HI_CNT)) begin
      raw.kind = RK_MASK; raw.q = QBITS'(off_mh) + 4'd8;
    end

    // R11: queues beyond the configured count decode to nothing
    sel_o = raw;
    if ({1'b0, raw.q} >= 5'(NUM_Q)) begin
      sel_o.kind = RK_NONE;
      sel_o.q    = '0;
    end
  end
endmodule

// File: rtl/mqirq_slot.sv
module mqirq_slot #(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] evt_i,
  input  logic          clr_i,
  input  logic          en_wr_i,
  input  logic          dis_wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          ack_i,
  output logic [DW-1:0] stat_o,
  output logic [DW-1:0] mask_o,
  output logic          irq_o
);
  logic [DW-1:0] stat_q, stat_d, mask_q, mask_d, new_bits;
  logic          stat_en, mask_en, irq_q, irq_d;

  always_comb begin
    new_bits = evt_i & ~mask_q;
    stat_d   = (clr_i ? '0 : stat_q) | new_bits;
    stat_en  = clr_i | (|new_bits);
    mask_en  = en_wr_i | dis_wr_i;
    mask_d   = en_wr_i ? (mask_q & ~wdata_i) : (mask_q | wdata_i);
    irq_d    = (|stat_d) & ((|new_bits) | (irq_q & ~ack_i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      mask_q <= '1;
      irq_q  <= 1'b0;
    end else begin
      if (stat_en) stat_q <= stat_d;
      if (mask_en) mask_q <= mask_d;
      irq_q <= irq_d;
    end
  end

  assign stat_o = stat_q;
  assign mask_o = mask_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/mq_irq_regbank.sv
module mq_irq_regbank
  import mqirq_pkg::*;
#(
  parameter int NUM_Q = 16,
  parameter int DW    = 32,
  parameter int AW    = 10
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic                we_i,
  input  logic [AW-1:0]       addr_i,
  input  logic [DW-1:0]       wdata_i,
  output logic [DW-1:0]       rdata_o,
  output logic                rvalid_o,
  input  logic [NUM_Q*DW-1:0] evt_i,
  output logic [NUM_Q-1:0]    irq_o
);
  // R13: legal range check
  if (NUM_Q < 1 || NUM_Q > MAXQ) begin : g_bad_nq
    $error("NUM_Q out of range 1..16");
  end

  rsel_t                    sel;
  logic                     rd, wr, gack;
  logic [NUM_Q-1:0][DW-1:0] stat_a, mask_a;
  logic [DW-1:0]            rdata_d, rdata_q;
  logic                     rvalid_q;

  mqirq_decode #(.AW(AW), .NUM_Q(NUM_Q)) u_dec (
    .addr_i (addr_i),
    .sel_o  (sel)
  );

  assign rd   = req_i & ~we_i;
  assign wr   = req_i & we_i;
  assign gack = rd & (sel.kind == RK_STAT) & (sel.q == 4'd0);

  for (genvar q = 0; q < NUM_Q; q++) begin : g_q
    logic hit;
    assign hit = (sel.q == 4'(q));
    mqirq_slot #(.DW(DW)) u_slot (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .evt_i    (evt_i[q*DW +: DW]),
      .clr_i    (rd & hit & (sel.kind == RK_STAT)),
      .en_wr_i  (wr & hit & (sel.kind == RK_EN)),
      .dis_wr_i (wr & hit & (sel.kind == RK_DIS)),
      .wdata_i  (wdata_i),
      .ack_i    (gack),
      .stat_o   (stat_a[q]),
      .mask_o   (mask_a[q]),
      .irq_o    (irq_o[q])
    );
  end

  always_comb begin
    rdata_d = '0;
    for (int q = 0; q < NUM_Q; q++) begin
      if (sel.q == 4'(q)) begin
        if (sel.kind == RK_STAT) rdata_d = stat_a[q];
        if (sel.kind == RK_MASK) rdata_d = mask_a[q];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      if (rd) rdata_q <= rdata_d;
      rvalid_q <= rd;
    end
  end

  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;
endmodule

// File: rtl/mqirq_chk.sv
module mqirq_chk
  import mqirq_pkg::*;
#(
  parameter int NUM_Q = 16,
  parameter int DW    = 32,
  parameter int AW    = 10
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                req_i,
  input logic                we_i,
  input logic [AW-1:0]       addr_i,
  input logic [DW-1:0]       rdata_o,
  input logic                rvalid_o,
  input logic [NUM_Q*DW-1:0] evt_i,
  input logic [NUM_Q-1:0]    irq_o,
  input logic [DW-1:0]       gstat,
  input logic [DW-1:0]       gmask
);
  // R12
  rvalid_after_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> $past(req_i && !we_i));

  // R9
  ack_drops_all_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i == AW'(GSTAT_W) && evt_i == '0) |=> irq_o == '0);

  // R8
  irq_needs_status_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o[0] |-> gstat != '0);

  // R4
  mask_only_by_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && we_i && (addr_i == AW'(GEN_W) || addr_i == AW'(GDIS_W))) |=> $stable(gmask));

  // R10
  strobe_reads_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && (addr_i == AW'(GEN_W) || addr_i == AW'(GDIS_W))) |=> (rvalid_o && rdata_o == '0));
endmodule

bind mq_irq_regbank mqirq_chk #(.NUM_Q(NUM_Q), .DW(DW), .AW(AW)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .req_i    (req_i),
  .we_i     (we_i),
  .addr_i   (addr_i),
  .rdata_o  (rdata_o),
  .rvalid_o (rvalid_o),
  .evt_i    (evt_i),
  .irq_o    (irq_o),
  .gstat    (stat_a[0]),
  .gmask    (mask_a[0])
);

// File: tb/sim_mq_irq_regbank.sv
`timescale 1ns/1ps
module sim_mq_irq_regbank;
  localparam int NQ = 10;
  localparam int DW = 32;
  localparam int AW = 10;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             req_i = 1'b0;
  logic             we_i = 1'b0;
  logic [AW-1:0]    addr_i = '0;
  logic [DW-1:0]    wdata_i = '0;
  logic [DW-1:0]    rdata_o;
  logic             rvalid_o;
  logic [NQ*DW-1:0] evt_i = '0;
  logic [NQ-1:0]    irq_o;

  int checks = 0;
  int errors = 0;
  logic [DW-1:0] exp_q[$];
  string         tag_q[$];

  always #2.5 clk_i = ~clk_i;

  mq_irq_regbank #(.NUM_Q(NQ), .DW(DW), .AW(AW)) u0 (.*);

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data as results appear
  always @(negedge clk_i) begin
    if (rvalid_o) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R12 unexpected rvalid actual=1 expected=0");
      end else begin
        check(tag_q.pop_front(), rdata_o, exp_q.pop_front());
      end
    end
  end

  task automatic wr(input int a, input logic [DW-1:0] d);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b1; addr_i = AW'(a >> 2); wdata_i = d;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic rd(input int a, input logic [DW-1:0] e, input string tag);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b0; addr_i = AW'(a >> 2);
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk_i);
    req_i = 1'b0;
  endtask

  task automatic pulse(input int q, input logic [DW-1:0] b);
    @(negedge clk_i);
    evt_i[q*DW +: DW] = b;
    @(negedge clk_i);
    evt_i = '0;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1 reset state
    check("R1 irq", 32'(irq_o), 32'h0);
    rd(32'h030, 32'hFFFF_FFFF, "R1 global mask");
    rd(32'h648, 32'hFFFF_FFFF, "R1 mask q3");
    rd(32'h400, 32'h0, "R1 status q1");
    // R13 output count
    check("R13 outputs", 32'($bits(irq_o)), 32'(NQ));
    // R6 masked event ignored
    pulse(2, 32'h1);
    check("R6 irq2", 32'(irq_o), 32'h0);
    rd(32'h404, 32'h0, "R6 status q2");
    // R4/R5 low window
    wr(32'h604, 32'h0000_00FF);
    rd(32'h644, 32'hFFFF_FF00, "R4 enable q2");
    wr(32'h624, 32'h0000_000F);
    rd(32'h644, 32'hFFFF_FF0F, "R4 disable q2");
    // R3/R8 latch and raise
    pulse(2, 32'h0000_0130);
    check("R8 irq q2 raised", 32'(irq_o), 32'h4);
    rd(32'h404, 32'h30, "R3 status q2");
    check("R8 irq q2 drops on clear", 32'(irq_o), 32'h0);
    rd(32'h404, 32'h0, "R7 status q2 cleared");
    // R4/R5 high window (queue 9)
    wr(32'h664, 32'hFFFF_FFFF);
    rd(32'h6A4, 32'h0, "R5 mask q9");
    wr(32'h684, 32'h8000_0000);
    rd(32'h6A4, 32'h8000_0000, "R4 disable q9");
    pulse(9, 32'hC000_0001);
    check("R8 irq q9", 32'(irq_o), 32'h200);
    // R2 global
    wr(32'h028, 32'h3);
    rd(32'h030, 32'hFFFF_FFFC, "R2 global mask");
    pulse(0, 32'h7);
    check("R8 irq q0 and q9", 32'(irq_o), 32'h201);
    rd(32'h024, 32'h3, "R2 global status");
    check("R9 all lines dropped", 32'(irq_o), 32'h0);
    rd(32'h420, 32'h4000_0001, "R9 q9 status kept");
    pulse(9, 32'h1);
    check("R9 re-raise on new bits", 32'(irq_o), 32'h200);
    // R7 event in the same cycle as a status read
    @(negedge clk_i);
    evt_i[2*DW +: DW] = 32'h10;
    req_i = 1'b1; we_i = 1'b0; addr_i = AW'(32'h404 >> 2);
    exp_q.push_back(32'h0); tag_q.push_back("R7 same-cycle read");
    @(negedge clk_i);
    evt_i = '0; req_i = 1'b0;
    rd(32'h404, 32'h10, "R7 same-cycle event kept");
    // R10 strobe reads zero, status write ignored
    rd(32'h604, 32'h0, "R10 strobe read");
    pulse(2, 32'h20);
    wr(32'h404, 32'hFFFF_FFFF);
    check("R12 no rvalid on write", 32'(rvalid_o), 32'h0);
    rd(32'h404, 32'h20, "R10 status write ignored");
    // R11 unconfigured queue 12
    wr(32'h670, 32'hFFFF_FFFF);
    rd(32'h6B0, 32'h0, "R11 mask q12");
    rd(32'h42C, 32'h0, "R11 status q12");
    repeat (3) @(negedge clk_i);
    check("R12 all reads answered", 32'(exp_q.size()), 32'h0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule